// File: doc/BRIEF.md
# Base-Register Effective Address Generator

This block turns a decoded memory-reference field into a 24-bit effective address for a machine whose 12-bit storage units are reached through base registers instead of fixed pages. It has two kinds of area. A single large area takes a 14-bit offset and so spans 16,384 storage units. Eight small areas each take an 11-bit offset and span 2,048 storage units. Each area has its own 24-bit base register, which gives a reachable space of 16,777,216 storage units.

The address is base plus offset, plus one of three index registers when the index selector is non-zero. The sum wraps modulo 2^24. If the reference is indirect, the block makes one memory read at that address. The 24-bit word that comes back is the final address, used unchanged, so there is only ever one level of indirection. The surrounding logic loads the base and index registers through a simple write port.

Top module: `base_addr_gen`

## Requirements
- R1: After reset `done`, `mem_req`, `mem_addr` and `eff_addr` are 0, and every base and index register holds 0.
- R2: When `start` is taken with `big_area`=1 and `indirect`=0, `done` is 1 in the next cycle and `eff_addr` = large base + zero-extended 14-bit `offset` (+ index), modulo 2^24.
- R3: When `big_area`=0, `area_sel` (0..7) selects the small-area base and only `offset[10:0]` is added. `offset[13:11]` has no effect.
- R4: `idx_sel`=0 adds nothing. `idx_sel`=1..3 adds index register 1..3. The sum keeps only its low 24 bits.
- R5: A register write shows up from the next cycle on. A computation in the same cycle as the write uses the old value.
- R6: When `start` is taken with `indirect`=1, `mem_req` is 1 in the next cycle, `mem_addr` holds the computed address, and `done` stays 0. Both `mem_req` and `mem_addr` hold steady until `mem_ack`.
- R7: One cycle after the cycle in which `mem_ack` is 1 while `mem_req` is 1, `done` is 1, `mem_req` is 0 and `eff_addr` equals `mem_rdata` unchanged. No second read is issued.
- R8: `start` is ignored while `mem_req` is 1.
- R9: `done` is a single-cycle pulse per operation. `eff_addr` changes only on a cycle where `done` is 1, and it holds its value otherwise.
- R10: `wr_sel` encoding: 0..7 select small base 0..7, 8 selects the large base, 9..11 select index register 1..3. Writes with `wr_sel` 12..15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 4 | Register to write (see R10) |
| wr_data | input | 24 | Value to write |
| start | input | 1 | Begin an address computation |
| big_area | input | 1 | 1: large area, 0: small area |
| area_sel | input | 3 | Small-area base select |
| offset | input | 14 | Offset; only the low 11 bits are used for small areas |
| idx_sel | input | 2 | Index register select, 0 = none |
| indirect | input | 1 | Fetch the final address from memory |
| mem_req | output | 1 | Indirect read request |
| mem_addr | output | 24 | Indirect read address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 24 | Read data (final address) |
| done | output | 1 | Result valid pulse |
| eff_addr | output | 24 | Effective address |

## Verification
A direct result is due on the first rising edge after the edge that accepts `start`. An indirect request is due on that same edge, and the indirect result is due one edge after the edge that samples `mem_ack`. The bench changes inputs 1 ns after a rising edge and reads the outputs at that same point. This means every check looks at the state that exactly one edge produced, and each check is timed to the edge that the requirement names. The bench also reads the outputs again one cycle later to confirm that `done` has dropped and `eff_addr` has held.

// File: rtl/base_addr_gen.sv
module base_addr_gen #(
  parameter int ADDR_W      = 24,
  parameter int BIG_OFF_W   = 14,
  parameter int SMALL_OFF_W = 11,
  parameter int NUM_SMALL   = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [$clog2(NUM_SMALL+5)-1:0] wr_sel,
  input  logic [ADDR_W-1:0]            wr_data,
  input  logic                         start,
  input  logic                         big_area,
  input  logic [$clog2(NUM_SMALL)-1:0] area_sel,
  input  logic [BIG_OFF_W-1:0]         offset,
  input  logic [1:0]                   idx_sel,
  input  logic                         indirect,
  output logic                         mem_req,
  output logic [ADDR_W-1:0]            mem_addr,
  input  logic                         mem_ack,
  input  logic [ADDR_W-1:0]            mem_rdata,
  output logic                         done,
  output logic [ADDR_W-1:0]            eff_addr
);
  localparam int WR_W = $clog2(NUM_SMALL + 5);

  logic [ADDR_W-1:0] small_base [NUM_SMALL];
  logic [ADDR_W-1:0] big_base;
  logic [ADDR_W-1:0] idx_reg [1:3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SMALL; i++) small_base[i] <= '0;
      for (int j = 1; j <= 3; j++) idx_reg[j] <= '0;
      big_base <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_SMALL; i++)
        if (wr_sel == WR_W'(i)) small_base[i] <= wr_data;
      if (wr_sel == WR_W'(NUM_SMALL)) big_base <= wr_data;
      for (int j = 1; j <= 3; j++)
        if (wr_sel == WR_W'(NUM_SMALL + j)) idx_reg[j] <= wr_data;
    end
  end

  wire [ADDR_W-1:0] base_v = big_area ? big_base : small_base[area_sel];
  wire [ADDR_W-1:0] off_v  = big_area ? {{(ADDR_W-BIG_OFF_W){1'b0}}, offset}
                                      : {{(ADDR_W-SMALL_OFF_W){1'b0}}, offset[SMALL_OFF_W-1:0]};
  wire [ADDR_W-1:0] idx_v  = (idx_sel == 2'd0) ? '0 : idx_reg[idx_sel];
  wire [ADDR_W-1:0] sum_v  = base_v + off_v + idx_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_req  <= 1'b0;
      mem_addr <= '0;
      done     <= 1'b0;
      eff_addr <= '0;
    end else begin
      done <= 1'b0;
      if (!mem_req) begin
        if (start) begin
          if (indirect) begin
            mem_req  <= 1'b1;
            mem_addr <= sum_v;
          end else begin
            done     <= 1'b1;
            eff_addr <= sum_v;
          end
        end
      end else if (mem_ack) begin
        mem_req  <= 1'b0;
        done     <= 1'b1;
        eff_addr <= mem_rdata;
      end
    end
  end
endmodule

// File: rtl/base_addr_gen_chk.sv
module base_addr_gen_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              indirect,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] mem_rdata,
  input logic              done,
  input logic [ADDR_W-1:0] eff_addr
);
  // R2
  direct_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !mem_req && !indirect |=> done && !mem_req);

  // R6
  ind_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !mem_req && indirect |=> mem_req && !done);

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  // R7
  ind_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> done && !mem_req && eff_addr == $past(mem_rdata));

  // R8
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> !done);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(eff_addr));
endmodule

bind base_addr_gen base_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .indirect(indirect),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .mem_rdata(mem_rdata), .done(done), .eff_addr(eff_addr)
);

// File: tb/tb_base_addr_gen.sv
module tb_base_addr_gen;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, wr_en, start, big_area, indirect, mem_ack;
  logic [3:0]  wr_sel;
  logic [23:0] wr_data, mem_rdata;
  logic [2:0]  area_sel;
  logic [13:0] offset;
  logic [1:0]  idx_sel;
  logic        mem_req, done;
  logic [23:0] mem_addr, eff_addr;

  base_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .start(start), .big_area(big_area), .area_sel(area_sel), .offset(offset),
    .idx_sel(idx_sel), .indirect(indirect), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .eff_addr(eff_addr)
  );

  int nvec = 0;
  int nfail = 0;
  logic [23:0] m_small [8];
  logic [23:0] m_big;
  logic [23:0] m_idx [4];

  task automatic chk(input bit ok, input string r, input logic [23:0] got, input logic [23:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", r, got, exp);
    end
  endtask

  function automatic logic [23:0] model(input bit big, input int sel, input logic [13:0] off, input int ix);
    logic [23:0] s;
    s = (big ? m_big : m_small[sel]) + (big ? {10'd0, off} : {13'd0, off[10:0]}) + m_idx[ix];
    return s;
  endfunction

  task automatic wr(input logic [3:0] s, input logic [23:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(posedge clk); #1 wr_en = 1'b0;
    if (s < 8) m_small[s] = d;
    else if (s == 8) m_big = d;
    else if (s <= 11) m_idx[s-8] = d;
  endtask

  task automatic direct(input bit big, input int sel, input logic [13:0] off, input int ix,
                        input logic [23:0] exp, input string r);
    big_area = big; area_sel = 3'(sel); offset = off; idx_sel = 2'(ix);
    indirect = 1'b0; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    chk(done === 1'b1 && eff_addr === exp && mem_req === 1'b0, r, eff_addr, exp);
    @(posedge clk); #1;
    chk(done === 1'b0 && eff_addr === exp, "R9", eff_addr, exp);
  endtask

  task automatic ind(input bit big, input int sel, input logic [13:0] off, input int ix,
                     input logic [23:0] rdata, input int lat);
    logic [23:0] exp;
    exp = model(big, sel, off, ix);
    big_area = big; area_sel = 3'(sel); offset = off; idx_sel = 2'(ix);
    indirect = 1'b1; start = 1'b1;
    @(posedge clk); #1 start = 1'b0; indirect = 1'b0;
    chk(mem_req === 1'b1 && done === 1'b0 && mem_addr === exp, "R6", mem_addr, exp);
    for (int k = 0; k < lat; k++) begin
      start = 1'b1; big_area = ~big;
      @(posedge clk); #1;
      chk(mem_req === 1'b1 && done === 1'b0 && mem_addr === exp, "R6/R8", mem_addr, exp);
    end
    start = 1'b0; mem_ack = 1'b1; mem_rdata = rdata;
    @(posedge clk); #1 mem_ack = 1'b0;
    chk(done === 1'b1 && mem_req === 1'b0 && eff_addr === rdata, "R7", eff_addr, rdata);
    @(posedge clk); #1;
    chk(done === 1'b0 && mem_req === 1'b0 && eff_addr === rdata, "R7/R9", eff_addr, rdata);
  endtask

  initial begin
    #2000000;
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [13:0] offs [3];
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; start = 1'b0;
    big_area = 1'b0; area_sel = '0; offset = '0; idx_sel = '0; indirect = 1'b0;
    mem_ack = 1'b0; mem_rdata = '0;
    for (int i = 0; i < 8; i++) m_small[i] = '0;
    for (int j = 0; j < 4; j++) m_idx[j] = '0;
    m_big = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: outputs and registers cleared
    chk(done === 1'b0 && mem_req === 1'b0 && eff_addr === 24'd0 && mem_addr === 24'd0,
        "R1", eff_addr, 24'd0);
    direct(1'b0, 5, 14'h0123, 3, 24'h000123, "R1");
    direct(1'b1, 0, 14'h3FFF, 2, 24'h003FFF, "R1");

    for (int i = 0; i < 8; i++) wr(4'(i), 24'h0A0000 + 24'h111111 * i);
    wr(4'd8, 24'hFFF000);
    wr(4'd9, 24'h000800);
    wr(4'd10, 24'h123456);
    wr(4'd11, 24'hFFFFF0);

    offs[0] = 14'h0000; offs[1] = 14'h07FF; offs[2] = 14'h3ABC;
    for (int s = 0; s < 8; s++)
      for (int ix = 0; ix < 4; ix++)
        for (int o = 0; o < 3; o++)
          direct(1'b0, s, offs[o], ix, model(1'b0, s, offs[o], ix), "R3/R4");

    offs[1] = 14'h3FFF; offs[2] = 14'h2AAA;
    for (int ix = 0; ix < 4; ix++)
      for (int o = 0; o < 3; o++)
        direct(1'b1, 7, offs[o], ix, model(1'b1, 7, offs[o], ix), "R2/R4");

    // R4: hand-worked wrap FFF000 + 3FFF + FFFFF0 = 002FEF (mod 2^24)
    direct(1'b1, 0, 14'h3FFF, 3, 24'h002FEF, "R4");
    // R3: upper offset bits ignored for small areas
    direct(1'b0, 1, 14'h3801, 0, 24'h1B1112, "R3");

    // R5: write and compute in the same cycle
    wr_en = 1'b1; wr_sel = 4'd2; wr_data = 24'h400000;
    big_area = 1'b0; area_sel = 3'd2; offset = 14'd5; idx_sel = 2'd0; indirect = 1'b0; start = 1'b1;
    @(posedge clk); #1 wr_en = 1'b0; start = 1'b0;
    chk(done === 1'b1 && eff_addr === 24'h2C2227, "R5", eff_addr, 24'h2C2227);
    m_small[2] = 24'h400000;
    direct(1'b0, 2, 14'd5, 0, 24'h400005, "R5");

    for (int lat = 0; lat < 4; lat++) begin
      ind(1'b0, lat, 14'h0456, lat, 24'hFFFFFF, lat);
      ind(1'b1, 0, 14'h3FF0, 3 - lat, 24'hABCDEF ^ 24'(lat), lat);
    end
    ind(1'b0, 7, 14'h07FF, 2, 24'h000000, 2);

    // R10: unused write selects change nothing
    wr(4'd12, 24'h5A5A5A); wr(4'd13, 24'h5A5A5A); wr(4'd14, 24'h5A5A5A); wr(4'd15, 24'h5A5A5A);
    for (int s = 0; s < 8; s++) direct(1'b0, s, 14'd0, 0, m_small[s], "R10");
    direct(1'b1, 0, 14'd0, 0, 24'hFFF000, "R10");
    for (int ix = 1; ix < 4; ix++) direct(1'b0, 0, 14'd0, ix, 24'h0A0000 + m_idx[ix], "R10");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule